// File: doc/BRIEF.md
# Serial Audio Link Output Frame Builder

This block assembles the outgoing frames of a serial audio codec link and shifts them out one bit per bit clock. Every frame is 256 bits: a 16-bit tag slot followed by twelve 20-bit slots. Slots 1 and 2 carry a one-deep codec command, made of an address and a data word. Slots 3 to 12 carry audio or modem samples taken from small per-channel queues. A per-slot enable and a per-slot channel selector decide which channel may fill each of those ten slots.

At the start of each frame the block takes a snapshot of the queues, the slot selectors and the pending command. It fills every enabled slot whose channel still has a sample waiting, working upward from slot 3, and marks only those slots valid in the tag. The finished 256-bit image is loaded into a shift register and sent MSB first, with frame sync high during the tag. Each channel reports whether it can take another sample and whether all of its samples have left the link. Any channel whose completion interrupt is enabled raises the interrupt line.

Top module: `aclink_tx_framer`

## Requirements
- R1: The frame is 256 bit clocks long and repeats with no gap. `link_sync` is high for the first 16 bit clocks of each frame and low for the other 240. The first frame begins on the first clock edge after reset is released.
- R2: Data is sent MSB first. The layout is a 16-bit tag followed by slots 1 to 12 of 20 bits each. In the tag, bit 15 is frame-valid, bit 14 minus (s-1) is the valid bit of slot s for s = 1..12, and bits 2..0 are zero.
- R3: A `cmd_wr` pulse stores `cmd_addr` and `cmd_data` and raises `cmd_busy`. The next frame to start carries them in slots 1 and 2 with both valid bits set, and `cmd_busy` then drops. Frames without a pending command have slots 1 and 2 zero and invalid.
- R4: `slot_on[k]` enables slot k+3 and `slot_map[k]` (channel number, CHW bits) selects its channel. Enabled slots are served in ascending slot order. Each slot takes the oldest waiting sample of its channel, and each sample occupies exactly one slot.
- R5: A channel with several waiting samples fills as many of its enabled slots as it has samples in one frame. Samples left over are sent in later frames.
- R6: A slot that is disabled, or whose channel has no sample waiting, is all zeros with its tag bit cleared. Frame-valid is set exactly when at least one slot in the frame is valid.
- R7: `ch_ready[c]` is high while channel c holds fewer than DEPTH samples. A write to a full channel is dropped.
- R8: `ch_empty[c]` is high when channel c holds no samples and the frame now being shifted carries none of its samples. It rises at the frame boundary after the last frame that carried one of its samples.
- R9: `irq` is high exactly when some channel c has both `ch_empty[c]` and `irq_en[c]` high.
- R10: During reset `link_sync` and `link_sdata` are low, every channel is ready and empty, and `cmd_busy` is low.
- R11: Slot enables and selectors are sampled only at frame start. A change made while a frame is being shifted does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all outputs change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_wr | input | 1 | Sample write strobe |
| smp_ch | input | CHW | Channel addressed by the write |
| smp_data | input | 20 | Sample value |
| cmd_wr | input | 1 | Codec command write strobe |
| cmd_addr | input | 20 | Command address word for slot 1 |
| cmd_data | input | 20 | Command data word for slot 2 |
| slot_on | input | 10 | Enable for slots 3..12 (bit k is slot k+3) |
| slot_map | input | 10*CHW | Channel number for each of slots 3..12 |
| irq_en | input | NCH | Per-channel enable of the completion interrupt |
| link_sync | output | 1 | Frame sync |
| link_sdata | output | 1 | Serial data out |
| ch_ready | output | NCH | Channel can accept another sample |
| ch_empty | output | NCH | Every sample of the channel has been shifted out |
| cmd_busy | output | 1 | A command is waiting for the next frame |
| irq | output | 1 | Completion interrupt request |

## Verification
The frame builder is driven with patterns that separate its allocation rules from one another:
- One sample per channel on two distinct slots shows that the channel selector is honoured.
- A run of samples on one channel over four slots, with two of the slots left empty, shows FIFO ordering and zeroing of empty slots.
- A command-only frame isolates the slot 1 and 2 path and its tag bits.
- Alternating slot ownership with three samples per channel checks the interleaving.
- All ten slots enabled with nothing queued must clear frame-valid.
- Surplus samples, and samples waiting on a channel with no slots, show that leftovers move into later frames.

Further directed cases cover the timing of status and configuration:
- An overrun write checks that a full queue drops data.
- The single clock at which the empty flag rises is checked.
- A selector rewrite in the middle of a frame must leave that frame intact.

// File: rtl/aclk_pkg.sv
package aclk_pkg;
  localparam int TAG_W   = 16;
  localparam int SLOT_W  = 20;
  localparam int NSLOT   = 13;
  localparam int NDATA   = 10;
  localparam int FRAME_W = TAG_W + SLOT_W * (NSLOT - 1);

  typedef logic [SLOT_W-1:0] slot_t;

  // Frame-vector index of the MSB of slot s (s = 1..12).
  function automatic int slot_msb(input int s);
    return FRAME_W - 1 - TAG_W - SLOT_W * (s - 1);
  endfunction

  // Tag word: frame-valid on top, then one bit per slot, slot 1 first.
  function automatic logic [TAG_W-1:0] tag_word(input logic [NSLOT-1:1] v);
    logic [TAG_W-1:0] t;
    t = '0;
    t[TAG_W-1] = |v;
    for (int s = 1; s < NSLOT; s++) t[TAG_W-1-s] = v[s];
    return t;
  endfunction
endpackage

// File: rtl/aclk_chan_queue.sv
module aclk_chan_queue
  import aclk_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    push,
  input  slot_t                   push_data,
  input  logic                    frame_load,
  input  logic [CW-1:0]           pop_n,
  output logic [DEPTH*SLOT_W-1:0] peek,
  output logic [CW-1:0]           cnt,
  output logic                    ready,
  output logic                    empty
);
  slot_t         mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt_q;
  logic          inflight;

  wire           push_ok = push && (cnt_q < CW'(DEPTH));
  wire  [CW-1:0] pop_eff = frame_load ? pop_n : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      cnt_q    <= '0;
      inflight <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + AW'(1);
      if (frame_load) begin
        rd_ptr   <= rd_ptr + pop_n[AW-1:0];
        inflight <= (pop_n != '0);
      end
      cnt_q <= cnt_q + CW'(push_ok) - pop_eff;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_peek
    assign peek[i*SLOT_W +: SLOT_W] = mem[rd_ptr + AW'(i)];
  end

  assign cnt   = cnt_q;
  assign ready = (cnt_q < CW'(DEPTH));
  assign empty = (cnt_q == '0) && !inflight;

  AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH)); // R7
  AST_POP_WITHIN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    frame_load |-> (pop_n <= cnt_q)); // R5
  AST_READY_FALLS_ON_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(push)); // R7
  AST_EMPTY_RISES_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(empty) |-> $past(frame_load)); // R8
endmodule

// File: rtl/aclk_frame_build.sv
module aclk_frame_build
  import aclk_pkg::*;
#(
  parameter int NCH   = 2,
  parameter int DEPTH = 4,
  localparam int AW  = $clog2(DEPTH),
  localparam int CW  = $clog2(DEPTH + 1),
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH*DEPTH*SLOT_W-1:0] peek,
  input  logic [NCH*CW-1:0]           cnt,
  input  logic [NDATA-1:0]            slot_on,
  input  logic [NDATA*CHW-1:0]        slot_map,
  input  logic                        cmd_pend,
  input  slot_t                       cmd_addr,
  input  slot_t                       cmd_data,
  output logic [FRAME_W-1:0]          frame,
  output logic [NCH*CW-1:0]           pop_n,
  output logic [NSLOT-1:1]            slot_valid
);
  logic [CW-1:0] taken [NCH];
  slot_t         sdat  [NSLOT-1:1];

  // Allocation: slots in ascending order, each takes its channel's oldest
  // sample not yet claimed by a lower slot in this frame.
  always_comb begin
    logic [CHW-1:0] own;
    for (int c = 0; c < NCH; c++) taken[c] = '0;
    sdat[1]       = cmd_pend ? cmd_addr : '0;
    sdat[2]       = cmd_pend ? cmd_data : '0;
    slot_valid[1] = cmd_pend;
    slot_valid[2] = cmd_pend;
    for (int k = 0; k < NDATA; k++) begin
      own             = slot_map[k*CHW +: CHW];
      sdat[k+3]       = '0;
      slot_valid[k+3] = 1'b0;
      if (slot_on[k] && (int'(own) < NCH)) begin
        if (taken[own] < cnt[int'(own)*CW +: CW]) begin
          slot_valid[k+3] = 1'b1;
          sdat[k+3] = peek[(int'(own)*DEPTH + int'(taken[own][AW-1:0]))*SLOT_W +: SLOT_W];
          taken[own] = taken[own] + CW'(1);
        end
      end
    end
    for (int c = 0; c < NCH; c++) pop_n[c*CW +: CW] = taken[c];
  end

  always_comb begin
    frame = '0;
    frame[FRAME_W-1 -: TAG_W] = tag_word(slot_valid);
    for (int s = 1; s < NSLOT; s++) frame[slot_msb(s) -: SLOT_W] = sdat[s];
  end
endmodule

// File: rtl/aclk_shifter.sv
module aclk_shifter
  import aclk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FRAME_W-1:0] frame_in,
  output logic               frame_load,
  output logic               sync,
  output logic               sdata
);
  localparam int BW = $clog2(FRAME_W);

  logic [BW-1:0]      bcnt;
  logic [FRAME_W-1:0] sr;

  assign frame_load = (bcnt == BW'(FRAME_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt <= BW'(FRAME_W - 1);
      sr   <= '0;
    end else begin
      bcnt <= frame_load ? '0 : bcnt + BW'(1);
      sr   <= frame_load ? frame_in : {sr[FRAME_W-2:0], 1'b0};
    end
  end

  assign sync  = (bcnt < BW'(TAG_W));
  assign sdata = sr[FRAME_W-1];

  AST_SYNC_RISE_AT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync) |-> $past(frame_load)); // R1
  AST_FIRST_BIT_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    frame_load |=> (sync && (sdata == $past(frame_in[FRAME_W-1])))); // R2
endmodule

// File: rtl/aclink_tx_framer.sv
module aclink_tx_framer
  import aclk_pkg::*;
#(
  parameter int NCH   = 2,
  parameter int DEPTH = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int CW  = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_wr,
  input  logic [CHW-1:0]       smp_ch,
  input  logic [SLOT_W-1:0]    smp_data,
  input  logic                 cmd_wr,
  input  logic [SLOT_W-1:0]    cmd_addr,
  input  logic [SLOT_W-1:0]    cmd_data,
  input  logic [NDATA-1:0]     slot_on,
  input  logic [NDATA*CHW-1:0] slot_map,
  input  logic [NCH-1:0]       irq_en,
  output logic                 link_sync,
  output logic                 link_sdata,
  output logic [NCH-1:0]       ch_ready,
  output logic [NCH-1:0]       ch_empty,
  output logic                 cmd_busy,
  output logic                 irq
);
  logic                       frame_load;
  logic [FRAME_W-1:0]         frame;
  logic [NSLOT-1:1]           slot_valid;
  logic [NCH*DEPTH*SLOT_W-1:0] peek_all;
  logic [NCH*CW-1:0]          cnt_all;
  logic [NCH*CW-1:0]          pop_all;
  logic                       cmd_pend;
  slot_t                      cmd_addr_q, cmd_data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_pend   <= 1'b0;
      cmd_addr_q <= '0;
      cmd_data_q <= '0;
    end else if (cmd_wr) begin
      cmd_pend   <= 1'b1;
      cmd_addr_q <= cmd_addr;
      cmd_data_q <= cmd_data;
    end else if (frame_load) begin
      cmd_pend   <= 1'b0;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    wire push_c = smp_wr && (int'(smp_ch) == c);
    aclk_chan_queue #(.DEPTH(DEPTH)) u_q (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (push_c),
      .push_data  (smp_data),
      .frame_load (frame_load),
      .pop_n      (pop_all[c*CW +: CW]),
      .peek       (peek_all[c*DEPTH*SLOT_W +: DEPTH*SLOT_W]),
      .cnt        (cnt_all[c*CW +: CW]),
      .ready      (ch_ready[c]),
      .empty      (ch_empty[c])
    );
  end

  aclk_frame_build #(.NCH(NCH), .DEPTH(DEPTH)) u_build (
    .peek       (peek_all),
    .cnt        (cnt_all),
    .slot_on    (slot_on),
    .slot_map   (slot_map),
    .cmd_pend   (cmd_pend),
    .cmd_addr   (cmd_addr_q),
    .cmd_data   (cmd_data_q),
    .frame      (frame),
    .pop_n      (pop_all),
    .slot_valid (slot_valid)
  );

  aclk_shifter u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_in   (frame),
    .frame_load (frame_load),
    .sync       (link_sync),
    .sdata      (link_sdata)
  );

  assign cmd_busy = cmd_pend;
  assign irq      = |(ch_empty & irq_en);

  AST_CMD_SENT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_load && cmd_pend && !cmd_wr) |=> !cmd_busy); // R3
  AST_TAG_LEADS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    frame_load |=> (link_sdata == $past(|slot_valid))); // R6
  AST_CMD_SLOTS_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    slot_valid[1] == slot_valid[2]); // R3
endmodule

// File: tb/tb_aclink_tx_framer.sv
module tb_aclink_tx_framer;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst_n = 1'b0;
  logic         smp_wr = 1'b0;
  logic [0:0]   smp_ch = '0;
  logic [19:0]  smp_data = '0;
  logic         cmd_wr = 1'b0;
  logic [19:0]  cmd_addr = 20'h5A3C1;
  logic [19:0]  cmd_data = 20'hC3E96;
  logic [9:0]   slot_on = '0;
  logic [9:0]   slot_map = '0;
  logic [1:0]   irq_en = '0;
  wire          link_sync, link_sdata, cmd_busy, irq;
  wire  [1:0]   ch_ready, ch_empty;

  aclink_tx_framer dut (
    .clk(clk), .rst_n(rst_n), .smp_wr(smp_wr), .smp_ch(smp_ch), .smp_data(smp_data),
    .cmd_wr(cmd_wr), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .slot_on(slot_on), .slot_map(slot_map), .irq_en(irq_en),
    .link_sync(link_sync), .link_sdata(link_sdata), .ch_ready(ch_ready),
    .ch_empty(ch_empty), .cmd_busy(cmd_busy), .irq(irq)
  );

  int n_chk = 0;
  int n_bad = 0;
  int seq = 1;
  logic [19:0] mq0[$];
  logic [19:0] mq1[$];

  // fields: n0[26:24] n1[23:21] cmd[20] slot_on[19:10] slot_map[9:0]
  localparam logic [26:0] VEC [9] = '{
    {3'd1, 3'd1, 1'b0, 10'h003, 10'h002},
    {3'd2, 3'd0, 1'b0, 10'h00F, 10'h000},
    {3'd0, 3'd0, 1'b1, 10'h000, 10'h000},
    {3'd3, 3'd3, 1'b0, 10'h3FF, 10'h2AA},
    {3'd0, 3'd0, 1'b0, 10'h3FF, 10'h000},
    {3'd4, 3'd2, 1'b0, 10'h007, 10'h000},
    {3'd0, 3'd0, 1'b0, 10'h200, 10'h200},
    {3'd1, 3'd1, 1'b1, 10'h3FF, 10'h3FF},
    {3'd0, 3'd0, 1'b0, 10'h001, 10'h000}
  };

  task automatic chk(input bit ok, input string what, input logic [255:0] got, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", what, got, exp);
    end
  endtask

  // Expected frame from the requirement text (R2, R3, R4, R6); consumes model queues.
  task automatic model_frame(input logic [9:0] on, input logic [9:0] map, input bit cmd,
                             output logic [255:0] e);
    logic [19:0] sl [12];
    logic [11:0] v;
    logic [15:0] tg;
    v = '0;
    for (int i = 0; i < 12; i++) sl[i] = '0;
    if (cmd) begin sl[0] = cmd_addr; sl[1] = cmd_data; v[0] = 1'b1; v[1] = 1'b1; end
    for (int k = 0; k < 10; k++) begin
      if (on[k]) begin
        if (!map[k] && mq0.size() > 0) begin sl[k+2] = mq0.pop_front(); v[k+2] = 1'b1; end
        else if (map[k] && mq1.size() > 0) begin sl[k+2] = mq1.pop_front(); v[k+2] = 1'b1; end
      end
    end
    tg = {|v, 15'b0};
    for (int i = 0; i < 12; i++) tg[14-i] = v[i];
    e = {240'b0, tg};
    for (int i = 0; i < 12; i++) e = {e[235:0], sl[i]};
  endtask

  task automatic push_sample(input int ch);
    logic [19:0] d;
    d = (ch == 0 ? 20'hA0000 : 20'hB0000) | 20'(seq);
    seq++;
    @(negedge clk);
    smp_wr = 1'b1; smp_ch = 1'(ch); smp_data = d;
    if (ch == 0) begin if (mq0.size() < 4) mq0.push_back(d); end
    else begin if (mq1.size() < 4) mq1.push_back(d); end
  endtask

  task automatic wait_start();
    logic last;
    last = link_sync;
    @(negedge clk);
    while (!(link_sync && !last)) begin last = link_sync; @(negedge clk); end
  endtask

  task automatic capture(output logic [255:0] f);
    wait_start();
    for (int p = 0; p < 256; p++) begin
      f[255-p] = link_sdata;
      if (p != 255) @(negedge clk);
    end
  endtask

  task automatic step(input int n0, input int n1, input bit cmd, input logic [9:0] on,
                      input logic [9:0] map, input int nfr, input string tag);
    logic [255:0] e, got;
    wait_start();
    slot_on = on; slot_map = map;
    for (int i = 0; i < n0; i++) push_sample(0);
    for (int i = 0; i < n1; i++) push_sample(1);
    if (cmd) begin @(negedge clk); smp_wr = 1'b0; cmd_wr = 1'b1; end
    @(negedge clk); smp_wr = 1'b0; cmd_wr = 1'b0;
    for (int f = 0; f < nfr; f++) begin
      model_frame(on, map, cmd && (f == 0), e);
      capture(got);
      chk(got === e, $sformatf("%s frame %0d", tag, f), got, e);
    end
    model_frame(on, map, 1'b0, e); // frame that follows, not observed
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [255:0] e, got, sv;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(link_sync === 1'b0, "R10 sync in reset", 256'(link_sync), 256'(0));
    chk(link_sdata === 1'b0, "R10 sdata in reset", 256'(link_sdata), 256'(0));
    chk(ch_ready === 2'b11, "R10 ready in reset", 256'(ch_ready), 256'(3));
    chk(ch_empty === 2'b11, "R10 empty in reset", 256'(ch_empty), 256'(3));
    chk(cmd_busy === 1'b0, "R10 busy in reset", 256'(cmd_busy), 256'(0));
    chk(irq === 1'b0, "R9 irq with no enables", 256'(irq), 256'(0));
    rst_n = 1'b1;

    // R1 sync shape and period
    wait_start();
    for (int p = 0; p < 256; p++) begin sv[255-p] = link_sync; @(negedge clk); end
    chk(sv === {16'hFFFF, 240'b0}, "R1 sync pattern", sv, {16'hFFFF, 240'b0});
    chk(link_sync === 1'b1, "R1 next frame at 256", 256'(link_sync), 256'(1));

    // Table of frame-content vectors: R2 R3 R4 R5 R6
    for (int i = 0; i < 9; i++) begin
      step(int'(VEC[i][26:24]), int'(VEC[i][23:21]), VEC[i][20], VEC[i][19:10], VEC[i][9:0], 1,
           $sformatf("R2/R4/R6 vector %0d", i));
    end

    // R7 overrun with slots disabled, then drain
    irq_en = 2'b01;
    step(5, 0, 1'b0, 10'h000, 10'h000, 1, "R6 idle frame");
    chk(ch_ready[0] === 1'b0, "R7 ready low when full", 256'(ch_ready[0]), 256'(0));
    chk(irq === 1'b0, "R9 irq low while queued", 256'(irq), 256'(0));
    step(0, 0, 1'b0, 10'h01F, 10'h000, 1, "R7 fifth write dropped");
    chk(ch_empty[0] === 1'b0, "R8 empty low on last carrying frame", 256'(ch_empty[0]), 256'(0));
    @(negedge clk);
    chk(ch_empty[0] === 1'b1, "R8 empty at boundary", 256'(ch_empty[0]), 256'(1));
    chk(irq === 1'b1, "R9 irq on empty", 256'(irq), 256'(1));
    chk(ch_ready[0] === 1'b1, "R7 ready after drain", 256'(ch_ready[0]), 256'(1));

    // R5 surplus spills into the next frame
    step(3, 0, 1'b0, 10'h003, 10'h000, 2, "R5 surplus");

    // R11 selector change mid-frame; R3 busy flag
    wait_start();
    slot_on = 10'h001; slot_map = 10'h000;
    push_sample(0);
    @(negedge clk); smp_wr = 1'b0; cmd_wr = 1'b1;
    @(negedge clk); cmd_wr = 1'b0;
    chk(cmd_busy === 1'b1, "R3 busy after write", 256'(cmd_busy), 256'(1));
    model_frame(10'h001, 10'h000, 1'b1, e);
    fork
      capture(got);
      begin
        wait_start();
        repeat (40) @(negedge clk);
        slot_on = 10'h3FF; slot_map = 10'h3FF;
      end
    join
    chk(got === e, "R11 frame unchanged by late map", got, e);
    chk(cmd_busy === 1'b0, "R3 busy cleared", 256'(cmd_busy), 256'(0));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule